// File: doc/BRIEF.md
# Voice-Coil DAC Control Word Target (two-wire serial)

This block is the serial control port of a 10-bit current-output converter that drives a lens actuator. It listens to a two-wire serial bus. SCL and SDA arrive as plain inputs sampled by a fast system clock. SDA is driven back through an open-drain enable. When a bus controller addresses the block, it takes a 16-bit control word as two bytes, sent high byte first and MSB first. Once the second byte has arrived, that word is copied into the converter register. The converter register supplies the 10-bit code and an active-high power-down flag.

A read with the same device address returns the stored 16-bit word in the same order it was written. After both bytes of a read have gone out, the stored word clears to zero. The device address is 0001100. The two low address bits are ignored, so four consecutive addresses select the block. A start or stop condition at any point ends the current transfer. A write that does not finish never changes the converter outputs.

Top module: `vcdac_i2c_target`

## Requirements
- R1: After synchronous reset, dac_code is 0, pwr_down is 0 and sda_oe is 0.
- R2: The first byte after a start is seven address bits followed by the direction bit. Addresses 0x0C to 0x0F are acknowledged. Any other address gets no acknowledge, and SDA is not driven for the rest of that transfer.
- R3: On a match, SDA is pulled low (sda_oe = 1) only after SCL has gone low following the eighth bit, and it stays low through the high phase of the ninth clock. The same acknowledge is given for each of the two written data bytes.
- R4: The written word is assembled as {first byte, second byte}. Bit 15 drives pwr_down, and bits 13 down to 4 drive dac_code bits 9 down to 0. Bits 14 and 3 to 0 have no effect on the outputs.
- R5: dac_code and pwr_down change only after the second data byte of a write. If a write stops after its first data byte, the outputs are unchanged.
- R6: A start condition seen in the middle of a byte abandons that transfer without updating the outputs. The block then treats the next byte as a fresh address byte.
- R7: A direction bit of 1 selects a read. The read returns the stored 16-bit word, high byte first and MSB first.
- R8: Once the second byte of a read has been clocked out, the stored word reads back as 0x0000. dac_code and pwr_down keep their values.
- R9: If the controller does not acknowledge the first read byte, the block stops driving SDA and keeps the stored word unchanged.
- R10: A direction bit of 0 selects a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| dac_code | output | 10 | Converter code from the converter register |
| pwr_down | output | 1 | Software power-down flag, active high |

## Verification
A wrong address decode or a bit counter that is out of step shows up at the ports within one byte. It appears as an acknowledge bit on SDA that is missing or extra, sampled during the ninth clock. A fault in word assembly or in the commit timing shows up on dac_code and pwr_down as soon as the stop that follows a write. Partial writes and aborted writes are checked by confirming that these outputs stay unchanged. Faults in the stored word or its clear-after-read behaviour are visible on the next read, one transfer later.

// File: rtl/vcdac_pkg.sv
package vcdac_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int CODE_W   = 10;
    localparam int CODE_LSB = 4;
    localparam int PD_BIT   = 15;
    localparam int IDX_W    = $clog2(WORD_W);
    localparam int CNT_W    = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic              pd;
        logic [CODE_W-1:0] code;
    } dac_out_t;

    function automatic logic addr_hit(input logic [6:0] rx,
                                      input logic [6:0] dev,
                                      input int         dc_bits);
        logic [6:0] mask;
        mask = 7'h7F << dc_bits;
        return (rx & mask) == (dev & mask);
    endfunction

    function automatic dac_out_t unpack_word(input logic [WORD_W-1:0] w);
        dac_out_t o;
        o.pd   = w[PD_BIT];
        o.code = w[CODE_LSB +: CODE_W];
        return o;
    endfunction

endpackage

// File: rtl/vcdac_bus_sync.sv
module vcdac_bus_sync
    import vcdac_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [1:0] line_in;
    logic [1:0] line_q;
    logic [1:0] line_prev;

    assign line_in = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe         <= '1;
                line_prev[g] <= 1'b1;
            end else begin
                pipe         <= {pipe[STAGES-2:0], line_in[g]};
                line_prev[g] <= pipe[STAGES-1];
            end
        end
        assign line_q[g] = pipe[STAGES-1];
    end

    always_comb begin
        ev.scl      = line_q[1];
        ev.sda      = line_q[0];
        ev.scl_rise = line_q[1] & ~line_prev[1];
        ev.scl_fall = ~line_q[1] & line_prev[1];
        ev.start    = line_q[1] & line_prev[1] & line_prev[0] & ~line_q[0];
        ev.stop     = line_q[1] & line_prev[1] & ~line_prev[0] & line_q[0];
    end

endmodule

// File: rtl/vcdac_byte_fsm.sv
module vcdac_byte_fsm
    import vcdac_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR     = 7'h0C,
    parameter int         ADDR_DC_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              rd_bit,
    output tgt_state_e        state,
    output logic [BYTE_W-1:0] byte_val,
    output logic              load_hi,
    output logic              commit,
    output logic              rd_clear,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              sda_oe
);

    logic [CNT_W-1:0] cnt;
    logic             full;
    logic             idx;
    logic             rw;
    logic             mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            full     <= 1'b0;
            idx      <= 1'b0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            byte_val <= '0;
            load_hi  <= 1'b0;
            commit   <= 1'b0;
            rd_clear <= 1'b0;
        end else begin
            load_hi  <= 1'b0;
            commit   <= 1'b0;
            rd_clear <= 1'b0;
            if (ev.start) begin
                state <= ST_ADDR;
                cnt   <= '0;
                full  <= 1'b0;
                idx   <= 1'b0;
            end else if (ev.stop) begin
                state <= ST_IDLE;
                full  <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (ev.scl_rise && !full) begin
                            byte_val <= {byte_val[BYTE_W-2:0], ev.sda};
                            cnt      <= cnt + 1'b1;
                            if (cnt == CNT_W'(BYTE_W - 1)) full <= 1'b1;
                        end else if (ev.scl_fall && full) begin
                            full <= 1'b0;
                            cnt  <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(byte_val[7:1], DEV_ADDR, ADDR_DC_BITS)) begin
                                    rw    <= byte_val[0];
                                    state <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else begin
                                state <= ST_WR_ACK;
                                if (idx) commit  <= 1'b1;
                                else     load_hi <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            idx   <= 1'b0;
                            state <= rw ? ST_RD_BYTE : ST_WR_BYTE;
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            if (!idx) begin
                                idx   <= 1'b1;
                                state <= ST_WR_BYTE;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev.scl_fall) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(BYTE_W - 1)) begin
                                cnt   <= '0;
                                state <= ST_RD_ACK;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (idx) begin
                                rd_clear <= 1'b1;
                                state    <= ST_WAIT;
                            end else if (mack) begin
                                idx   <= 1'b1;
                                state <= ST_RD_BYTE;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_idx = {idx, cnt};

    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~rd_bit;
            default:                sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/vcdac_word_regs.sv
module vcdac_word_regs
    import vcdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              load_hi,
    input  logic              commit,
    input  logic              rd_clear,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_bit,
    output dac_out_t          dac_q
);

    logic [BYTE_W-1:0] hi_hold;
    logic [WORD_W-1:0] in_word;
    logic [WORD_W-1:0] new_word;

    assign new_word = {hi_hold, byte_val};

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_hold <= '0;
            in_word <= '0;
            dac_q   <= '0;
        end else begin
            if (load_hi) hi_hold <= byte_val;
            if (commit) begin
                in_word <= new_word;
                dac_q   <= unpack_word(new_word);
            end else if (rd_clear) begin
                in_word <= '0;
            end
        end
    end

    assign rd_bit = in_word[IDX_W'(WORD_W - 1) - rd_idx];

endmodule

// File: rtl/vcdac_i2c_target.sv
module vcdac_i2c_target
    import vcdac_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR     = 7'h0C,
    parameter int         ADDR_DC_BITS = 2,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [CODE_W-1:0] dac_code,
    output logic              pwr_down
);

    bus_ev_t           ev;
    tgt_state_e        state;
    logic [BYTE_W-1:0] byte_val;
    logic              load_hi;
    logic              commit;
    logic              rd_clear;
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_bit;
    dac_out_t          dac_q;

    vcdac_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    vcdac_byte_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_DC_BITS(ADDR_DC_BITS)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rd_bit   (rd_bit),
        .state    (state),
        .byte_val (byte_val),
        .load_hi  (load_hi),
        .commit   (commit),
        .rd_clear (rd_clear),
        .rd_idx   (rd_idx),
        .sda_oe   (sda_oe)
    );

    vcdac_word_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .byte_val (byte_val),
        .load_hi  (load_hi),
        .commit   (commit),
        .rd_clear (rd_clear),
        .rd_idx   (rd_idx),
        .rd_bit   (rd_bit),
        .dac_q    (dac_q)
    );

    assign dac_code = dac_q.code;
    assign pwr_down = dac_q.pd;

endmodule

// File: rtl/vcdac_i2c_target_chk.sv
module vcdac_i2c_target_chk
    import vcdac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input tgt_state_e        state,
    input logic              commit,
    input logic              load_hi,
    input logic              rd_clear,
    input logic              start_det,
    input logic              scl_fall,
    input logic              sda_oe,
    input logic [CODE_W-1:0] dac_code,
    input logic              pwr_down
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (dac_code == '0) && !pwr_down && !sda_oe);

    a_r2_no_drive_on_miss: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_ADDR && state == ST_WAIT) |-> !sda_oe);

    a_r3_ack_on_low: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_ADDR_ACK) |-> $past(scl_fall));

    a_r5_outputs_move_on_commit: assert property (@(posedge clk) disable iff (rst)
        !($stable(dac_code) && $stable(pwr_down)) |-> $past(commit));

    a_r6_start_restarts: assert property (@(posedge clk) disable iff (rst)
        start_det |=> state == ST_ADDR);

    a_r8_clear_after_read_ack: assert property (@(posedge clk) disable iff (rst)
        rd_clear |-> $past(state) == ST_RD_ACK);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        $onehot0({commit, load_hi, rd_clear}));

endmodule

bind vcdac_i2c_target vcdac_i2c_target_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .commit    (commit),
    .load_hi   (load_hi),
    .rd_clear  (rd_clear),
    .start_det (ev.start),
    .scl_fall  (ev.scl_fall),
    .sda_oe    (sda_oe),
    .dac_code  (dac_code),
    .pwr_down  (pwr_down)
);

// File: tb/tb_vcdac_i2c_target.sv
module tb_vcdac_i2c_target;

    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [9:0] dac_code;
    logic       pwr_down;
    logic       sda_bus;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    logic [9:0] exp_code = '0;
    logic       exp_pd   = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    vcdac_i2c_target dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .dac_code (dac_code),
        .pwr_down (pwr_down)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req);
        chk({req, " code"}, int'(dac_code), int'(exp_code));
        chk({req, " pd"}, int'(pwr_down), int'(exp_pd));
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        tick(Q);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q);
        r = sda_bus; tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            b[i] = r;
        end
        clk_bit(~give_ack, r);
    endtask

    task automatic write_word(input logic [6:0] a, input logic [15:0] w,
                              output logic aa, output logic ah, output logic al);
        bus_start();
        send_byte({a, 1'b0}, aa);
        ah = 1'b0; al = 1'b0;
        if (aa) begin
            send_byte(w[15:8], ah);
            send_byte(w[7:0], al);
        end
        bus_stop();
    endtask

    task automatic read_word(input logic [6:0] a, output logic [15:0] w, output logic aa);
        logic [7:0] hi, lo;
        bus_start();
        send_byte({a, 1'b1}, aa);
        recv_byte(1'b1, hi);
        recv_byte(1'b0, lo);
        w = {hi, lo};
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin : main
        logic aa, ah, al, r;
        logic [15:0] w, rw;
        logic [7:0]  hb;

        tick(6);
        rst = 1'b0;
        tick(2);
        // R1: reset state
        chk("R1 code", int'(dac_code), 0);
        chk("R1 pd", int'(pwr_down), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);

        // R2, R3, R4, R10: sweep every 7-bit address
        for (int a = 0; a < 128; a++) begin
            logic hit;
            hit = (a[6:2] == 5'b00011);
            w = 16'h4000 | 16'(a << 4) | 16'(a & 1) << 15 | 16'h000A;
            write_word(7'(a), w, aa, ah, al);
            chk("R2 address ack", int'(aa), int'(hit));
            if (hit) begin
                chk("R3 data ack hi", int'(ah), 1);
                chk("R3 data ack lo", int'(al), 1);
                exp_code = w[13:4];
                exp_pd   = w[15];
            end
            tick(4);
            chk_out("R10/R2 outputs");
        end

        // R4, R7, R8: word patterns with write, read back, read-clear
        for (int k = 0; k < 32; k++) begin
            w = 16'((k * 16'h9E37) ^ (k << 11) ^ 16'h5A5A);
            write_word(7'h0C + 7'(k & 3), w, aa, ah, al);
            exp_code = w[13:4];
            exp_pd   = w[15];
            tick(4);
            chk_out("R4 word fields");
            read_word(7'h0D, rw, aa);
            chk("R7 read ack", int'(aa), 1);
            chk("R7 read data", int'(rw), int'(w));
            read_word(7'h0E, rw, aa);
            chk("R8 cleared read", int'(rw), 0);
            chk_out("R8 outputs kept");
        end

        // R5: write that stops after one data byte
        bus_start();
        send_byte(8'h18, aa);
        send_byte(8'hBF, ah);
        bus_stop();
        tick(4);
        chk_out("R5 partial write");

        // R6: repeated start in the middle of the second byte, then a full write
        bus_start();
        send_byte(8'h18, aa);
        send_byte(8'h3F, ah);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, r);
        bus_start();
        tick(4);
        chk_out("R6 aborted write");
        send_byte(8'h1A, aa);
        chk("R6 re-address ack", int'(aa), 1);
        send_byte(8'hA5, ah);
        send_byte(8'hC3, al);
        bus_stop();
        exp_code = 10'(16'hA5C3 >> 4);
        exp_pd   = 1'b1;
        tick(4);
        chk_out("R6 write after restart");

        // R9: NACK after first read byte keeps the word, no drive afterwards
        bus_start();
        send_byte(8'h19, aa);
        recv_byte(1'b0, hb);
        chk("R9 first byte", int'(hb), 16'hA5);
        recv_byte(1'b0, hb);
        chk("R9 released after nack", int'(hb), 8'hFF);
        bus_stop();
        read_word(7'h0F, rw, aa);
        chk("R9 word kept", int'(rw), 16'hA5C3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule